// File: doc/BRIEF.md
# Pipelined AES Round-Key Scheduler

This block feeds a fully pipelined AES datapath with one pipeline stage per round. Each clock cycle it may accept a cipher key together with a valid strobe. It expands that key inside a chain of registered stages, and each stage derives the next four schedule words from the running window of words that came before it. Round key r is therefore produced in the same cycle that round stage r of the datapath is working on the block that belongs to that key. A key is presented once, in the cycle it is needed, and then it leaves the block. Only the schedule window moves forward.

The key size (128, 192 or 256 bits) is an instance parameter, so instances of different sizes can sit in one design. A second parameter reverses the order in which the keys are presented, for an inverse-cipher pipeline. In that mode the last round key goes to the first stage. Short delay lines inside the block keep every key aligned with its stage, so the datapath does no buffering of its own.

Top module: `aes_rk_sched`

## Requirements
- R1: Parameter KEY_BITS is 128, 192 or 256 and gives NR = 10, 12 or 14 rounds. The block has NR+1 output entries of 128 bits each. Entry e sits at rk_out[128*e +: 128], and its first schedule word is in bits 127:96 of that entry. The key input carries schedule word 0 in its most significant 32 bits.
- R2: Every key presented equals the standard AES expansion. RotWord, SubWord and an XOR of the round constant (01,02,04,…,80,1B,36) are applied to every NK-th word. For 256-bit keys, SubWord alone is applied where the word index mod 8 is 4. With the standard example keys, the final round key matches the published words.
- R3: With REVERSE=0, entry r carries round key r. A key captured at a rising edge appears on entry r after r further rising edges, so entry 0 is visible right after the capture edge.
- R4: With REVERSE=1, entry j carries round key NR-j. It is visible NR+j rising edges after the capture edge.
- R5: A new key may be captured on every edge. Keys captured on consecutive edges never mix on any entry.
- R6: rk_valid[e] is high exactly when entry e carries a key captured with key_valid high. A key offered with key_valid low never appears as valid.
- R7: While rst_n is low, all of rk_valid is low. After reset, an entry reports valid only once a captured key has reached it.
- R8: key_valid never holds an unknown value outside reset, and key_in holds no unknown value whenever key_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset, clears the valid flags |
| key_valid | input | 1 | Capture strobe for key_in |
| key_in | input | KEY_BITS | Cipher key, word 0 in the top bits |
| rk_out | output | 128*(NR+1) | Round keys, one entry per datapath stage |
| rk_valid | output | NR+1 | Valid flag per entry |

## Verification
The bench records each key and strobe against the index of the edge that captures it. After every rising edge, on the following falling edge, it compares every entry of four instances: three key sizes in forward order and one 256-bit instance in reverse order. The expected contents of entry e come from the key captured L edges earlier, where L is e in forward order and NR+e in reverse order. When that earlier capture is before reset release, or was offered with the strobe low, the entry must read invalid. The standard example keys are issued on three consecutive edges, and their final round keys are compared with the published words exactly NR edges later, and also on entry 0 of the reversed instance at that same edge.

// File: rtl/aes_rk_pkg.sv
package aes_rk_pkg;

   localparam int RK_BITS = 128;
   localparam int WORD_BITS = 32;

   function automatic logic [7:0] gf_x2(input logic [7:0] a);
      return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
   endfunction

   function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
      logic [7:0] acc, aa, bb;
      acc = 8'h00;
      aa  = a;
      bb  = b;
      for (int k = 0; k < 8; k++) begin
         if (bb[0]) acc = acc ^ aa;
         aa = gf_x2(aa);
         bb = bb >> 1;
      end
      return acc;
   endfunction

   // Multiplicative inverse as x^254, then the affine map.
   function automatic logic [7:0] sub_byte(input logic [7:0] x);
      logic [7:0] sq, inv, s;
      sq  = x;
      inv = 8'h01;
      for (int k = 1; k < 8; k++) begin
         sq  = gf_mul(sq, sq);
         inv = gf_mul(inv, sq);
      end
      s = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
              ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
      return s;
   endfunction

   function automatic logic [31:0] sub_word(input logic [31:0] w);
      return {sub_byte(w[31:24]), sub_byte(w[23:16]), sub_byte(w[15:8]), sub_byte(w[7:0])};
   endfunction

   function automatic logic [31:0] rot_word(input logic [31:0] w);
      return {w[23:0], w[31:24]};
   endfunction

   // Round constant for n >= 1, generated by repeated doubling.
   function automatic logic [7:0] round_const(input int n);
      logic [7:0] r;
      r = 8'h01;
      for (int k = 1; k < n; k++) r = gf_x2(r);
      return r;
   endfunction

   // Transform applied to word i-1 before it is folded into word i.
   function automatic logic [31:0] word_mix(input logic [31:0] t, input int i, input int nk);
      if (i % nk == 0)
         return sub_word(rot_word(t)) ^ {round_const(i / nk), 24'h000000};
      else if (nk > 6 && (i % nk) == 4)
         return sub_word(t);
      else
         return t;
   endfunction

endpackage

// File: rtl/aes_rk_stage.sv
module aes_rk_stage
   import aes_rk_pkg::*;
#(
   parameter int NK   = 4,
   parameter int BASE = 0,
   localparam int WIN_BITS = WORD_BITS * NK
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [WIN_BITS-1:0] in_win,
   output logic                out_valid,
   output logic [WIN_BITS-1:0] out_win
);

   if (NK < 4 || NK > 8) begin : g_bad_nk
      $error("aes_rk_stage: NK must lie in 4..8");
   end

   logic [WORD_BITS-1:0] cur_w [NK];
   logic [WORD_BITS-1:0] new_w [4];
   logic [WORD_BITS-1:0] nxt_w [NK];
   logic [WIN_BITS-1:0]  nxt_flat;

   always_comb begin
      for (int w = 0; w < NK; w++)
         cur_w[w] = in_win[WORD_BITS*(NK-1-w) +: WORD_BITS];
   end

   // Four fresh words: w[i] = w[i-NK] ^ mix(w[i-1]).
   always_comb begin
      logic [WORD_BITS-1:0] prev;
      prev = cur_w[NK-1];
      for (int k = 0; k < 4; k++) begin
         new_w[k] = cur_w[k] ^ word_mix(prev, BASE + NK + k, NK);
         prev = new_w[k];
      end
   end

   // Slide the window forward by one round key.
   always_comb begin
      for (int w = 0; w < NK; w++) begin
         if (w < NK - 4) nxt_w[w] = cur_w[w+4];
         else            nxt_w[w] = new_w[w-(NK-4)];
      end
      for (int w = 0; w < NK; w++)
         nxt_flat[WORD_BITS*(NK-1-w) +: WORD_BITS] = nxt_w[w];
   end

   always_ff @(posedge clk) begin
      out_win <= nxt_flat;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_valid <= 1'b0;
      else        out_valid <= in_valid;
   end

endmodule

// File: rtl/aes_rk_delay.sv
module aes_rk_delay #(
   parameter int DEPTH = 2,
   parameter int W     = 128
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic [W-1:0] in_data,
   output logic         out_valid,
   output logic [W-1:0] out_data
);

   if (DEPTH < 0) begin : g_bad_depth
      $error("aes_rk_delay: DEPTH must not be negative");
   end

   if (DEPTH == 0) begin : g_wire
      assign out_valid = in_valid;
      assign out_data  = in_data;
   end else begin : g_shift
      logic [W-1:0] dat_q [DEPTH];
      logic [DEPTH-1:0] vld_q;

      always_ff @(posedge clk) begin
         dat_q[0] <= in_data;
         for (int k = 1; k < DEPTH; k++) dat_q[k] <= dat_q[k-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) vld_q <= '0;
         else if (DEPTH == 1) vld_q <= in_valid;
         else vld_q <= {vld_q[DEPTH-2:0], in_valid};
      end

      assign out_valid = vld_q[DEPTH-1];
      assign out_data  = dat_q[DEPTH-1];
   end

endmodule

// File: rtl/aes_rk_sched.sv
module aes_rk_sched
   import aes_rk_pkg::*;
#(
   parameter int KEY_BITS = 128,
   parameter bit REVERSE  = 1'b0,
   localparam int NK  = KEY_BITS / 32,
   localparam int NR  = NK + 6,
   localparam int NRK = NR + 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   key_valid,
   input  logic [KEY_BITS-1:0]    key_in,
   output logic [RK_BITS*NRK-1:0] rk_out,
   output logic [NRK-1:0]         rk_valid
);

   if (KEY_BITS != 128 && KEY_BITS != 192 && KEY_BITS != 256) begin : g_bad_size
      $error("aes_rk_sched: KEY_BITS must be 128, 192 or 256");
   end

   localparam int WIN_BITS = WORD_BITS * NK;

   logic [WIN_BITS-1:0] win   [NRK];
   logic                win_v [NRK];

   // Stage 0 holds the raw key; its top four words are round key 0.
   always_ff @(posedge clk) begin
      win[0] <= key_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) win_v[0] <= 1'b0;
      else        win_v[0] <= key_valid;
   end

   for (genvar s = 1; s < NRK; s++) begin : g_stage
      aes_rk_stage #(.NK(NK), .BASE(4*(s-1))) u_stage (
         .clk       (clk),
         .rst_n     (rst_n),
         .in_valid  (win_v[s-1]),
         .in_win    (win[s-1]),
         .out_valid (win_v[s]),
         .out_win   (win[s])
      );
   end

   if (!REVERSE) begin : g_fwd
      for (genvar e = 0; e < NRK; e++) begin : g_ent
         assign rk_out[RK_BITS*e +: RK_BITS] = win[e][WIN_BITS-1 -: RK_BITS];
         assign rk_valid[e] = win_v[e];
      end

      // R3: entry 0 is the key captured at the previous edge.
      a_r3_first_entry: assert property (@(posedge clk) disable iff (!rst_n)
         rk_valid[0] |-> rk_out[RK_BITS-1:0] == $past(key_in[KEY_BITS-1 -: RK_BITS]));
   end else begin : g_rev
      // Entry j shows round key NR-j; it is made at edge NR-j, used at NR+j.
      for (genvar j = 0; j < NRK; j++) begin : g_ent
         logic [RK_BITS-1:0] d_key;
         logic               d_vld;
         aes_rk_delay #(.DEPTH(2*j), .W(RK_BITS)) u_dly (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (win_v[NR-j]),
            .in_data   (win[NR-j][WIN_BITS-1 -: RK_BITS]),
            .out_valid (d_vld),
            .out_data  (d_key)
         );
         assign rk_out[RK_BITS*j +: RK_BITS] = d_key;
         assign rk_valid[j] = d_vld;
      end
   end

   // R8: inputs free of unknowns.
   a_r8_valid_known: assert property (@(posedge clk) disable iff (!rst_n)
      !$isunknown(key_valid));
   a_r8_key_known: assert property (@(posedge clk) disable iff (!rst_n)
      key_valid |-> !$isunknown(key_in));

   for (genvar e = 0; e < NRK; e++) begin : g_chk
      // R2: a valid entry never carries unknown bits.
      a_r2_entry_known: assert property (@(posedge clk) disable iff (!rst_n)
         rk_valid[e] |-> !$isunknown(rk_out[RK_BITS*e +: RK_BITS]));
      if (e > 0) begin : g_walk
         // R6: each entry lags its neighbour by exactly one edge.
         a_r6_valid_walk: assert property (@(posedge clk) disable iff (!rst_n)
            rk_valid[e] == $past(rk_valid[e-1]));
      end
   end

endmodule

// File: tb/tb_aes_rk_sched.sv
`timescale 1ns/1ps
module tb_aes_rk_sched;

   localparam int NCYC = 420;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic key_valid = 1'b0;
   logic [255:0] key_bus = '0;

   always #10 clk = ~clk;

   logic [128*11-1:0] o128;  logic [10:0] v128;
   logic [128*13-1:0] o192;  logic [12:0] v192;
   logic [128*15-1:0] o256;  logic [14:0] v256;
   logic [128*15-1:0] orev;  logic [14:0] vrev;

   aes_rk_sched #(.KEY_BITS(128), .REVERSE(1'b0)) dut (
      .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_in(key_bus[255 -: 128]),
      .rk_out(o128), .rk_valid(v128));
   aes_rk_sched #(.KEY_BITS(192), .REVERSE(1'b0)) dut_b (
      .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_in(key_bus[255 -: 192]),
      .rk_out(o192), .rk_valid(v192));
   aes_rk_sched #(.KEY_BITS(256), .REVERSE(1'b0)) dut_c (
      .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_in(key_bus),
      .rk_out(o256), .rk_valid(v256));
   aes_rk_sched #(.KEY_BITS(256), .REVERSE(1'b1)) dut_d (
      .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_in(key_bus),
      .rk_out(orev), .rk_valid(vrev));

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [7:0] sb [256];
   logic [7:0] rc [11];
   logic        vh   [NCYC];
   logic [59:0][31:0] e128 [NCYC];
   logic [59:0][31:0] e192 [NCYC];
   logic [59:0][31:0] e256 [NCYC];

   // S-box built by walking the generator 3 and its inverse.
   task automatic build_tables();
      logic [7:0] p, q, x;
      p = 8'h01; q = 8'h01;
      do begin
         p = p ^ {p[6:0], 1'b0} ^ (p[7] ? 8'h1b : 8'h00);
         q = q ^ {q[6:0], 1'b0};
         q = q ^ {q[5:0], 2'b00};
         q = q ^ {q[3:0], 4'h0};
         if (q[7]) q = q ^ 8'h09;
         x = q ^ {q[6:0], q[7]} ^ {q[5:0], q[7:6]} ^ {q[4:0], q[7:5]} ^ {q[3:0], q[7:4]};
         sb[p] = x ^ 8'h63;
      end while (p != 8'h01);
      sb[0] = 8'h63;
      rc[1] = 8'h01;
      for (int k = 2; k < 11; k++) rc[k] = {rc[k-1][6:0], 1'b0} ^ (rc[k-1][7] ? 8'h1b : 8'h00);
   endtask

   function automatic logic [31:0] sw(input logic [31:0] w);
      return {sb[w[31:24]], sb[w[23:16]], sb[w[15:8]], sb[w[7:0]]};
   endfunction

   function automatic logic [59:0][31:0] expand(input int nk, input logic [255:0] key);
      logic [59:0][31:0] w;
      logic [31:0] t;
      w = '0;
      for (int i = 0; i < nk; i++) w[i] = key[255-32*i -: 32];
      for (int i = nk; i < 60; i++) begin
         t = w[i-1];
         if (i % nk == 0) t = sw({t[23:0], t[31:24]}) ^ {(i/nk < 11 ? rc[i/nk] : 8'h00), 24'h0};
         else if (nk == 8 && i % 8 == 4) t = sw(t);
         w[i] = w[i-nk] ^ t;
      end
      return w;
   endfunction

   task automatic check(input string req, input string what, input logic [127:0] got,
                        input logic [127:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FIAL_GUARD");
      end
   endtask

   task automatic chk(input string req, input string nm, input logic [127:0] got,
                      input logic [127:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s: got %h expected %h", req, nm, got, exp);
      end
   endtask

   // Compare every entry of one instance for capture-edge index c.
   task automatic chk_inst(input string nm, input int nk, input bit rev,
                           input logic [128*15-1:0] flat, input logic [14:0] vf, input int c);
      int nr, lat, ridx, src;
      logic ev;
      logic [127:0] ek;
      logic [59:0][31:0] w;
      nr = nk + 6;
      for (int e = 0; e <= nr; e++) begin
         lat  = rev ? nr + e : e;
         ridx = rev ? nr - e : e;
         src  = c - lat;
         ev   = (src >= 0) ? vh[src] : 1'b0;
         chk(src < 0 ? "R7" : "R6", $sformatf("%s valid[%0d] @%0d", nm, e, c),
             {127'b0, vf[e]}, {127'b0, ev});
         if (ev && vf[e] === 1'b1) begin
            w  = (nk == 4) ? e128[src] : (nk == 6) ? e192[src] : e256[src];
            ek = {w[4*ridx], w[4*ridx+1], w[4*ridx+2], w[4*ridx+3]};
            chk(rev ? "R4" : "R3", $sformatf("%s key[%0d] @%0d (R5 stream)", nm, e, c),
                flat[128*e +: 128], ek);
         end
      end
   endtask

   localparam logic [255:0] K128 = {128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h0};
   localparam logic [255:0] K192 = {192'h8e73b0f7da0e6452c810f32b809079e562f8ead2522c6b7b, 64'h0};
   localparam logic [255:0] K256 = 256'h603deb1015ca71be2b73aef0857d77811f352c073b6108d72d9810a30914dff4;
   localparam logic [127:0] L128 = 128'hd014f9a8c9ee2589e13f0cc8b6630ca6;
   localparam logic [127:0] L192 = 128'he98ba06f448c773c8ecc720401002202;
   localparam logic [127:0] L256 = 128'hfe4890d1e6188d0b046df344706c631e;

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      logic [59:0][31:0] w;
      void'($urandom(32'h5eed_1234));
      build_tables();
      // R2: bench model against published final round keys.
      w = expand(4, K128); chk("R2", "model 128", {w[40], w[41], w[42], w[43]}, L128);
      w = expand(6, K192); chk("R2", "model 192", {w[48], w[49], w[50], w[51]}, L192);
      w = expand(8, K256); chk("R2", "model 256", {w[56], w[57], w[58], w[59]}, L256);

      repeat (3) @(negedge clk);
      // R7: reset state, with a valid key offered during reset.
      key_valid = 1'b1; key_bus = K128;
      @(posedge clk); @(negedge clk);
      chk("R7", "valid in reset 128", {117'b0, v128}, '0);
      chk("R7", "valid in reset 256 rev", {113'b0, vrev}, '0);
      key_valid = 1'b0;
      rst_n = 1'b1;

      for (int c = 0; c < NCYC; c++) begin
         // Inputs for the edge with index c.
         if (c == 0)      begin key_valid = 1'b1; key_bus = K128; end
         else if (c == 1) begin key_valid = 1'b1; key_bus = K192; end
         else if (c == 2) begin key_valid = 1'b1; key_bus = K256; end
         else if (c == 3) begin key_valid = 1'b1; key_bus = '0; end
         else if (c == 4) begin key_valid = 1'b1; key_bus = '1; end
         else if (c == 5) begin key_valid = 1'b0; key_bus = {8{32'hdeadbeef}}; end // R6 ignored
         else if (c >= NCYC - 32) begin key_valid = 1'b0; key_bus = '0; end
         else begin
            key_valid = ($urandom % 4) != 0;
            for (int k = 0; k < 8; k++) key_bus[32*k +: 32] = $urandom;
         end
         vh[c]   = key_valid;
         e128[c] = expand(4, {key_bus[255 -: 128], 128'h0});
         e192[c] = expand(6, {key_bus[255 -: 192], 64'h0});
         e256[c] = expand(8, key_bus);
         @(posedge clk);
         @(negedge clk);
         chk_inst("k128", 4, 1'b0, {512'b0, o128}, {4'b0, v128}, c);
         chk_inst("k192", 6, 1'b0, {256'b0, o192}, {2'b0, v192}, c);
         chk_inst("k256", 8, 1'b0, o256, v256, c);
         chk_inst("k256rev", 8, 1'b1, orev, vrev, c);
         // R1: published final round keys on the last entry, back-to-back keys.
         if (c == 10) chk("R1", "128 last entry", o128[128*10 +: 128], L128);
         if (c == 13) chk("R1", "192 last entry", o192[128*12 +: 128], L192);
         if (c == 16) chk("R1", "256 last entry", o256[128*14 +: 128], L256);
         if (c == 16) chk("R4", "256 reverse entry 0", orev[127:0], L256);
      end
      finish_run();
   end

endmodule